// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block copies a chosen subset of a sixteen-entry, 32-bit register file to consecutive memory locations, or fills that subset from memory. It makes one memory transfer at a time. A 16-bit selection mask picks the registers. The operation also takes a direction, a word/long operand size, an addressing-mode code with its register field, and a start address that an address calculator outside the block has already worked out. Register indices 0-7 are the data registers and indices 8-15 are the address registers.

For each transfer the sequencer drives a single register-file port and a single request/acknowledge memory port. It walks the set mask bits and jumps over clear bits without spending extra cycles. In the pre-decrement mode (mode 4) it reverses the mapping from mask bit to register and decrements the address before each access. In every other mode it increments the address after each access.

When the walk is over, the sequencer raises a one-cycle done pulse. The pulse comes with the final address and a cycle-cost total. That total is a base cost set by the mode plus a cost for each register moved. In the post-increment load case and in the pre-decrement store case, the final address is also written back to the base address register through the register-file port.

Top module: `blkx_seq`

## Requirements
- R1: In normal order, the lowest set mask bit is transferred first, and mask bit i selects register index i (0-7 data, 8-15 address).
- R2: In mode 4 (pre-decrement), mask bit i selects register index 15-i. Bit 0 selects A7 (index 15) and bit 15 selects D0 (index 0). The lowest set bit still goes first.
- R3: In mode 4, each access uses the running address minus the step, and that becomes the new running address. In all other modes, the access uses the running address and the running address then advances by the step. The final address reported at done is the running address after the last transfer.
- R4: A size input of 0 means word: step 2, a load writes the sign-extended low 16 bits of mem_rdata into the register, and a store drives mem_wdata with bits 31:16 zero and bits 15:0 taken from the register. A size input of 1 means long: step 4, and the full 32 bits move in both directions.
- R5: In the done cycle, rf_we is high with rf_idx = 8 + base register field and rf_wdata = final address, but only for a load in mode 3 or a store in mode 4. Otherwise rf_we is low in the done cycle. During transfers, rf_we is high only in a load's acknowledge cycle.
- R6: The reported cost is the base cost plus 4 per register for word size, or plus 8 per register for long size.
- R7: The load base cost is: mode 2: 12, mode 3: 12, mode 5: 16, mode 6: 18, mode 7 with register 0: 16, register 1: 20, register 2: 16, register 3: 18. The store base cost is: mode 2: 8, mode 4: 8, mode 5: 12, mode 6: 14, mode 7 with register 0: 12, register 1: 16.
- R8: An all-zero mask makes no memory request. It completes with the base cost only and with the final address equal to the start address.
- R9: Only one request is ever outstanding. While mem_req is high without mem_ack, the address, register index and size stay stable. There is no request in the done cycle.
- R10: start is accepted only when idle, and a start during an operation has no effect. done lasts exactly one cycle. After done the block stays idle and makes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| to_mem | input | 1 | 1: registers to memory, 0: memory to registers |
| size_long | input | 1 | 0: word, 1: long |
| ea_mode | input | 3 | Addressing-mode code |
| ea_reg | input | 3 | Mode register field (base address register) |
| sel_mask | input | 16 | Register selection mask |
| start_addr | input | 32 | Precomputed start address |
| rf_idx | output | 4 | Register-file index for the current access |
| rf_rdata | input | 32 | Register-file read data for rf_idx |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (store) |
| mem_long | output | 1 | Access is 32-bit |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| final_addr | output | 32 | Address after the last transfer |
| cost_total | output | 16 | Accumulated cycle cost |

## Verification
The bench checks the reversed bit-to-register mapping in pre-decrement stores, using masks that mix bit 0 and bit 15. A design that kept normal order there would write D0 where A7 belongs, and would leave its decremented address one step off. Word loads come from memory values with bit 15 set, so a design that zero-extends instead of sign-extending shows up. Register values with non-zero upper halves expose word stores that leak those bits. An all-zero mask, a full mask, and write-back versus no write-back for each mode catch a wrong final address, a spurious base-register write, and a wrong cost. Varying acknowledge latency and a start pulse injected mid-operation catch a sequencer that skips ahead before acknowledge or restarts while busy.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } blkx_state_e;

   // addressing-mode codes the sequencer reacts to
   localparam logic [2:0] MODE_IND  = 3'd2;
   localparam logic [2:0] MODE_POST = 3'd3;
   localparam logic [2:0] MODE_PRE  = 3'd4;
   localparam logic [2:0] MODE_DISP = 3'd5;
   localparam logic [2:0] MODE_INDX = 3'd6;
   localparam logic [2:0] MODE_EXT  = 3'd7;

   localparam int unsigned UNIT_WORD = 4;
   localparam int unsigned UNIT_LONG = 8;

endpackage

// File: rtl/blkx_pick.sv
// Lowest-set-bit selector; PICK_STYLE picks a priority loop (0) or
// an isolate-and-encode structure (1).
module blkx_pick #(
   parameter int W          = 16,
   parameter int PICK_STYLE = 1,
   localparam int PW        = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [PW-1:0] pos,
   output logic [W-1:0]  lowbit
);

   if (W < 2) begin : g_bad_w
      $error("blkx_pick: W must be at least 2");
   end
   if (PICK_STYLE != 0 && PICK_STYLE != 1) begin : g_bad_style
      $error("blkx_pick: PICK_STYLE must be 0 or 1");
   end

   assign any = |vec;

   if (PICK_STYLE == 0) begin : g_loop
      always_comb begin
         pos    = '0;
         lowbit = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
               pos = PW'(i);
            end
         end
         if (|vec) begin
            lowbit[pos] = 1'b1;
         end
      end
   end else begin : g_isolate
      assign lowbit = vec & (~vec + W'(1));
      for (genvar b = 0; b < PW; b++) begin : g_enc
         logic [W-1:0] sel;
         for (genvar i = 0; i < W; i++) begin : g_term
            assign sel[i] = lowbit[i] & (((i >> b) & 1) == 1);
         end
         assign pos[b] = |sel;
      end
   end

   always_comb begin
      if (!$isunknown(vec) && |vec) begin
         AST_PICK_HIT: assert (vec[pos] && (lowbit == (W'(1) << pos))); // R1
      end
   end

endmodule

// File: rtl/blkx_cost.sv
// Mode-dependent base cost and per-register cost.
module blkx_cost #(
   parameter int COST_W = 16,
   parameter int RW     = 3
) (
   input  logic              to_mem,
   input  logic [2:0]        mode,
   input  logic [RW-1:0]     rg,
   input  logic              xfer_long,
   output logic [COST_W-1:0] base,
   output logic [COST_W-1:0] unit
);
   import blkx_pkg::*;

   if (COST_W < 8) begin : g_bad_cost
      $error("blkx_cost: COST_W too narrow for the largest total");
   end
   if (RW < 2) begin : g_bad_rw
      $error("blkx_cost: RW must be at least 2");
   end

   logic [7:0] b8;

   always_comb begin
      b8 = 8'd0;
      if (!to_mem) begin
         unique case (mode)
            MODE_IND, MODE_POST: b8 = 8'd12;
            MODE_DISP:           b8 = 8'd16;
            MODE_INDX:           b8 = 8'd18;
            MODE_EXT: begin
               unique case (rg[1:0])
                  2'd0:    b8 = 8'd16;
                  2'd1:    b8 = 8'd20;
                  2'd2:    b8 = 8'd16;
                  default: b8 = 8'd18;
               endcase
               if (rg > RW'(3)) b8 = 8'd0;
            end
            default: b8 = 8'd0;
         endcase
      end else begin
         unique case (mode)
            MODE_IND, MODE_PRE: b8 = 8'd8;
            MODE_DISP:          b8 = 8'd12;
            MODE_INDX:          b8 = 8'd14;
            MODE_EXT: begin
               if (rg == RW'(0))      b8 = 8'd12;
               else if (rg == RW'(1)) b8 = 8'd16;
               else                   b8 = 8'd0;
            end
            default: b8 = 8'd0;
         endcase
      end
   end

   assign base = COST_W'(b8);
   assign unit = xfer_long ? COST_W'(UNIT_LONG) : COST_W'(UNIT_WORD);

endmodule

// File: rtl/blkx_step.sv
// Access address and next running address for one transfer.
module blkx_step #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] run_addr,
   input  logic              xfer_long,
   input  logic              pre_dec,
   output logic [ADDR_W-1:0] step,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] nxt_addr
);

   if (ADDR_W < 8) begin : g_bad_aw
      $error("blkx_step: ADDR_W too small");
   end

   logic [ADDR_W-1:0] down;

   assign step     = xfer_long ? ADDR_W'(4) : ADDR_W'(2);
   assign down     = run_addr - step;
   assign acc_addr = pre_dec ? down : run_addr;
   assign nxt_addr = pre_dec ? down : run_addr + step;

endmodule

// File: rtl/blkx_seq.sv
module blkx_seq #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NREG       = 16,
   parameter int COST_W     = 16,
   parameter int PICK_STYLE = 1,
   localparam int IDX_W     = $clog2(NREG),
   localparam int RW        = IDX_W - 1,
   localparam int HALF_W    = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              to_mem,
   input  logic              size_long,
   input  logic [2:0]        ea_mode,
   input  logic [RW-1:0]     ea_reg,
   input  logic [NREG-1:0]   sel_mask,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [IDX_W-1:0]  rf_idx,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              rf_we,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_long,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] final_addr,
   output logic [COST_W-1:0] cost_total
);
   import blkx_pkg::*;

   if (DATA_W != 32) begin : g_bad_dw
      $error("blkx_seq: DATA_W must be 32");
   end
   if (ADDR_W != DATA_W) begin : g_bad_aw
      $error("blkx_seq: ADDR_W must equal DATA_W for write-back");
   end
   if (NREG < 4 || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("blkx_seq: NREG must be a power of two, at least 4");
   end

   blkx_state_e       st_q;
   logic [NREG-1:0]   pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [COST_W-1:0] cost_q;
   logic              to_mem_q;
   logic              long_q;
   logic [2:0]        mode_q;
   logic [RW-1:0]     reg_q;

   logic              pend_any;
   logic [IDX_W-1:0]  pend_pos;
   logic [NREG-1:0]   pend_low;
   logic [COST_W-1:0] base_cost;
   logic [COST_W-1:0] unit_cost;
   logic [ADDR_W-1:0] step_w;
   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] nxt_addr;
   logic              pre_dec;
   logic              wb_en;
   logic              xfer_ack;
   logic [IDX_W-1:0]  xfer_idx;
   logic [DATA_W-1:0] load_val;

   blkx_pick #(.W(NREG), .PICK_STYLE(PICK_STYLE)) u_pick (
      .vec    (pend_q),
      .any    (pend_any),
      .pos    (pend_pos),
      .lowbit (pend_low)
   );

   blkx_cost #(.COST_W(COST_W), .RW(RW)) u_cost (
      .to_mem    (to_mem),
      .mode      (ea_mode),
      .rg        (ea_reg),
      .xfer_long (long_q),
      .base      (base_cost),
      .unit      (unit_cost)
   );

   blkx_step #(.ADDR_W(ADDR_W)) u_step (
      .run_addr  (addr_q),
      .xfer_long (long_q),
      .pre_dec   (pre_dec),
      .step      (step_w),
      .acc_addr  (acc_addr),
      .nxt_addr  (nxt_addr)
   );

   assign pre_dec  = (mode_q == MODE_PRE);
   assign wb_en    = (!to_mem_q && mode_q == MODE_POST) ||
                     ( to_mem_q && mode_q == MODE_PRE);
   assign xfer_idx = pre_dec ? IDX_W'(NREG - 1) - pend_pos : pend_pos;

   assign mem_req  = (st_q == ST_RUN) && pend_any;
   assign xfer_ack = mem_req && mem_ack;
   assign mem_we   = mem_req && to_mem_q;
   assign mem_long = long_q;
   assign mem_addr = acc_addr;

   assign mem_wdata = long_q ? rf_rdata : {{HALF_W{1'b0}}, rf_rdata[HALF_W-1:0]};
   assign load_val  = long_q ? mem_rdata
                             : {{HALF_W{mem_rdata[HALF_W-1]}}, mem_rdata[HALF_W-1:0]};

   assign done       = (st_q == ST_FIN);
   assign final_addr = addr_q;
   assign cost_total = cost_q;

   always_comb begin
      rf_idx   = xfer_idx;
      rf_we    = xfer_ack && !to_mem_q;
      rf_wdata = load_val;
      if (st_q == ST_FIN) begin
         rf_idx   = {1'b1, reg_q};
         rf_we    = wb_en;
         rf_wdata = DATA_W'(addr_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         pend_q   <= '0;
         addr_q   <= '0;
         cost_q   <= '0;
         to_mem_q <= 1'b0;
         long_q   <= 1'b0;
         mode_q   <= '0;
         reg_q    <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q     <= ST_RUN;
                  pend_q   <= sel_mask;
                  addr_q   <= start_addr;
                  cost_q   <= base_cost;
                  to_mem_q <= to_mem;
                  long_q   <= size_long;
                  mode_q   <= ea_mode;
                  reg_q    <= ea_reg;
               end
            end
            ST_RUN: begin
               if (!pend_any) begin
                  st_q <= ST_FIN;
               end else if (mem_ack) begin
                  pend_q <= pend_q & ~pend_low;
                  addr_q <= nxt_addr;
                  cost_q <= cost_q + unit_cost;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(rf_idx)
                              && $stable(mem_long)); // R9

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !mem_req); // R10

   AST_POST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack && !pre_dec && ($countones(pend_q) > 1)
      |=> mem_req && (mem_addr == $past(mem_addr) + $past(step_w))); // R3

   AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack && pre_dec && ($countones(pend_q) > 1)
      |=> mem_req && (mem_addr == $past(mem_addr) - $past(step_w))); // R3

   AST_RF_WRITE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (mem_ack && mem_req && !mem_we) || done); // R5

   AST_COST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |=> cost_total == $past(cost_total) + (mem_long ? COST_W'(8) : COST_W'(4))); // R6

endmodule

// File: tb/blkx_seq_test.sv
module blkx_seq_test;

   localparam int CLK_P = 10;

   typedef struct packed {
      logic        to_mem;
      logic        lng;
      logic [2:0]  mode;
      logic [2:0]  rg;
      logic [15:0] mask;
      logic [31:0] addr;
      logic [15:0] base;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 3'd3, 3'd2, 16'h0105, 32'h0000_0040, 16'd12},
      '{1'b0, 1'b1, 3'd5, 3'd1, 16'h8001, 32'h0000_0010, 16'd16},
      '{1'b1, 1'b0, 3'd4, 3'd7, 16'h8001, 32'h0000_0080, 16'd8},
      '{1'b1, 1'b1, 3'd2, 3'd3, 16'h00F0, 32'h0000_0020, 16'd8},
      '{1'b0, 1'b1, 3'd7, 3'd1, 16'hFFFF, 32'h0000_0010, 16'd20},
      '{1'b1, 1'b1, 3'd7, 3'd0, 16'h0300, 32'h0000_0050, 16'd12},
      '{1'b0, 1'b0, 3'd6, 3'd4, 16'h0002, 32'h0000_0060, 16'd18},
      '{1'b1, 1'b1, 3'd4, 3'd6, 16'hC000, 32'h0000_00A0, 16'd8},
      '{1'b0, 1'b0, 3'd7, 3'd3, 16'h0000, 32'h0000_0070, 16'd18},
      '{1'b0, 1'b1, 3'd7, 3'd2, 16'h0010, 32'h0000_0030, 16'd16},
      '{1'b1, 1'b0, 3'd6, 3'd5, 16'h0001, 32'h0000_0090, 16'd14}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        to_mem = 1'b0;
   logic        size_long = 1'b0;
   logic [2:0]  ea_mode = 3'd0;
   logic [2:0]  ea_reg = 3'd0;
   logic [15:0] sel_mask = 16'h0;
   logic [31:0] start_addr = 32'h0;
   logic [3:0]  rf_idx;
   logic [31:0] rf_rdata;
   logic        rf_we;
   logic [31:0] rf_wdata;
   logic        mem_req, mem_we, mem_long;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = 32'h0;
   logic        done;
   logic [31:0] final_addr;
   logic [15:0] cost_total;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   function automatic logic [31:0] reg_val(input logic [3:0] k);
      return 32'h5A00_0000 | (32'(k) << 16) | 32'h0000_9000 | 32'(k);
   endfunction

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return {16'h1357 ^ a[15:0], 16'h8000 | a[15:0]};
   endfunction

   assign rf_rdata = reg_val(rf_idx);

   blkx_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem),
      .size_long(size_long), .ea_mode(ea_mode), .ea_reg(ea_reg),
      .sel_mask(sel_mask), .start_addr(start_addr), .rf_idx(rf_idx),
      .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .done(done), .final_addr(final_addr),
      .cost_total(cost_total)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic run_op(input vec_t v, input bit poke);
      int          n;
      int          k;
      int          waits;
      bit          pre;
      bit          seen_done;
      logic [31:0] step;
      logic [31:0] run_a;
      logic [31:0] exp_a [16];
      logic [3:0]  exp_i [16];
      logic [31:0] ev;
      bit          exp_wb;
      n = 0;
      pre = (v.mode == 3'd4);
      step = v.lng ? 32'd4 : 32'd2;
      run_a = v.addr;
      for (int i = 0; i < 16; i++) begin
         if (v.mask[i]) begin
            exp_i[n] = pre ? 4'(15 - i) : 4'(i);
            if (pre) begin
               run_a = run_a - step;
               exp_a[n] = run_a;
            end else begin
               exp_a[n] = run_a;
               run_a = run_a + step;
            end
            n++;
         end
      end
      exp_wb = (!v.to_mem && v.mode == 3'd3) || (v.to_mem && v.mode == 3'd4);

      @(negedge clk);
      start = 1'b1; to_mem = v.to_mem; size_long = v.lng; ea_mode = v.mode;
      ea_reg = v.rg; sel_mask = v.mask; start_addr = v.addr;
      k = 0; waits = 0; seen_done = 1'b0;
      for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
         @(negedge clk);
         start = 1'b0;
         mem_ack = 1'b0;
         if (poke && k == 1) begin
            // a start while busy must be ignored (R10)
            start = 1'b1; to_mem = ~v.to_mem; sel_mask = 16'hFFFF;
            ea_mode = 3'd2; start_addr = 32'h0000_00F0;
         end
         #1;
         if (done) begin
            seen_done = 1'b1;
            chk(k == n, "R1 transfer count", 32'(k), 32'(n));
            chk(final_addr == run_a, "R3 final address", final_addr, run_a);
            ev = 32'(v.base) + 32'(n) * (v.lng ? 32'd8 : 32'd4);
            chk(32'(cost_total) == ev, "R6/R7 cost", 32'(cost_total), ev);
            chk(rf_we == exp_wb, "R5 write-back enable", 32'(rf_we), 32'(exp_wb));
            if (exp_wb) begin
               chk(rf_idx == 4'(8 + v.rg), "R5 write-back index", 32'(rf_idx), 32'(8 + v.rg));
               chk(rf_wdata == run_a, "R5 write-back data", rf_wdata, run_a);
            end
            chk(!mem_req, "R9 no request at done", 32'(mem_req), 32'h0);
         end else if (mem_req) begin
            if (k >= n) begin
               chk(1'b0, "R8 unexpected request", mem_addr, 32'h0);
               k++;
            end else if (waits == (k % 3)) begin
               mem_rdata = mem_val(mem_addr);
               mem_ack = 1'b1;
               #1;
               chk(mem_addr == exp_a[k], pre ? "R2/R3 address" : "R1/R3 address",
                   mem_addr, exp_a[k]);
               chk(rf_idx == exp_i[k], pre ? "R2 register order" : "R1 register order",
                   32'(rf_idx), 32'(exp_i[k]));
               chk(mem_we == v.to_mem && mem_long == v.lng, "R4 access kind",
                   {30'h0, mem_we, mem_long}, {30'h0, v.to_mem, v.lng});
               if (v.to_mem) begin
                  ev = v.lng ? reg_val(exp_i[k]) : {16'h0, reg_val(exp_i[k])[15:0]};
                  chk(mem_wdata == ev, "R4 store data", mem_wdata, ev);
               end else begin
                  ev = v.lng ? mem_val(exp_a[k]) : {{16{mem_val(exp_a[k])[15]}}, mem_val(exp_a[k])[15:0]};
                  chk(rf_we && rf_wdata == ev, "R4 load data", rf_wdata, ev);
               end
               k++;
               waits = 0;
            end else begin
               waits++;
            end
         end
      end
      mem_ack = 1'b0;
      if (!seen_done) chk(1'b0, "R10 done never seen", 32'(k), 32'(n));
      @(negedge clk);
      chk(!done, "R10 done one cycle", 32'(done), 32'h0);
      repeat (3) begin
         @(negedge clk);
         chk(!mem_req && !done, "R10 idle after done", {30'h0, mem_req, done}, 32'h0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!done && !mem_req && !rf_we, "R10 reset state",
          {29'h0, done, mem_req, rf_we}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !mem_req, "R9 idle without start", {30'h0, done, mem_req}, 32'h0);

      for (int t = 0; t < NV; t++) begin
         run_op(VECS[t], 1'b0);
      end

      // R8: empty mask in a write-back mode leaves the address unchanged
      run_op('{1'b1, 1'b0, 3'd4, 3'd3, 16'h0000, 32'h0000_00C0, 16'd8}, 1'b0);
      // R10: start during an operation is ignored
      run_op('{1'b0, 1'b1, 3'd3, 3'd1, 16'h0C03, 32'h0000_0008, 16'd12}, 1'b1);
      // R2: full pre-decrement store, word size
      run_op('{1'b1, 1'b0, 3'd4, 3'd0, 16'hFFFF, 32'h0000_0100, 16'd8}, 1'b0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule